// File: doc/BRIEF.md
# Descriptor Chain Walker

This block is the sequencing half of a single memory-to-memory transfer channel. Software places a linked list of fixed-size descriptors in memory, writes the address of the first one into a next-pointer register and turns the channel on. The walker reads each descriptor through a one-word-at-a-time memory read port and passes the decoded operation to a datapath with a start pulse. It waits for the datapath to report done, then follows the descriptor's link word. A link word of zero ends the chain.

Progress is reported through sticky flags in a status register and through three level interrupt lines. The flags mark a completed descriptor that asked for an interrupt, the end of the chain, and four kinds of error. Software clears each flag by writing a one to its bit. After the chain has ended, software can add descriptors to its tail and set a resume bit. The walker then reads the link word of the last descriptor again and carries on from there if the link is now nonzero.

Top module: `dchain_ctrl`

## Requirements
- R1: After reset the control, status and current-address registers read 0, all three interrupt lines are low and no memory request is raised.
- R2: Register map (byte offsets): control 0x00, status 0x04, current descriptor address 0x08 (read only), next descriptor address 0x24 (read/write). Writing control bit 0 from 0 to 1 while idle starts a chain at the next-descriptor address. Status bit 13 reads 1 while the channel is working. Offset 0x08 returns the address of the descriptor being processed, or of the last one processed.
- R3: A descriptor is 7 words. Word k is read from current address + 4k. The datapath receives word 1 as control, word 2 as aux, the low 24 bits of word 3 as the byte count, word 4 as destination and word 6 as source, with a single-cycle start pulse.
- R4: A nonzero link (word 0) is followed once the datapath reports done. A zero link stops the channel and sets status bit 11 (end of chain).
- R5: A completed descriptor sets status bit 12 (end of transfer) only when bit 0 of its control word is 1.
- R6: Status bits 12, 11, 9, 5, 4 and 3 are sticky. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle as the clear wins.
- R7: Control bit 1 (resume) stays pending until the channel is idle at a chain end with bit 0 set. The walker then reads word 0 of the last descriptor once and clears bit 1. A nonzero value starts fetching from that address. A zero value leaves the channel idle with the current address unchanged.
- R8: Clearing control bit 0 during a chain stops the channel after the descriptor in flight completes: no further descriptor is started and busy drops.
- R9: A memory response code on any descriptor read halts the channel with busy low and no datapath start. Code 1 sets status bit 3, code 2 sets bit 4 and code 3 sets bit 5. Code 0 means success.
- R10: A parity error reported with the datapath's done sets status bit 9, halts the chain, and sets neither bit 12 nor bit 11.
- R11: irq_eot follows status bit 12, irq_eoc follows bit 11, and irq_err is the OR of bits 9, 5, 4 and 3.
- R12: A start with a zero next-descriptor address issues no memory read and sets bit 11 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| mem_req | output | 1 | Descriptor word read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of requested word |
| mem_ack | input | 1 | Read acknowledge, with data and response |
| mem_resp | input | 2 | Response code, 0 = success |
| mem_rdata | input | 32 | Read data |
| op_start | output | 1 | One-cycle start to the datapath |
| op_ctrl | output | 32 | Descriptor control word |
| op_aux | output | 32 | Descriptor aux word |
| op_count | output | 24 | Byte count |
| op_dst | output | 32 | Destination address |
| op_src | output | 32 | Source address |
| op_done | input | 1 | Datapath completion pulse |
| op_perr | input | 1 | Parity error, qualified by op_done |
| irq_eot | output | 1 | End-of-transfer interrupt |
| irq_eoc | output | 1 | End-of-chain interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The walker is driven with a single descriptor, a three-descriptor chain and a chain that is extended at its tail. Together these separate link following from chain termination, and show that the end-of-transfer flag depends on each descriptor's own control bit. A resume with a still-zero link, a start with a zero pointer, and a disable while the first of two descriptors is in flight show the walker stopping without any further datapath activity. Memory responses of each error code and a datapath parity error check that every failure lands in its own status bit and stops the chain. An all-ones count word checks that the byte count is cut to its field width.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  // register byte offsets
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_CUR  = 8'h08;
  localparam logic [7:0] OFS_NEXT = 8'h24;

  // status bit positions
  localparam int BIT_BUSY = 13;
  localparam int BIT_EOT  = 12;
  localparam int BIT_EOC  = 11;

  // descriptor word slots
  localparam int W_LINK = 0;
  localparam int W_CTRL = 1;
  localparam int W_AUX  = 2;
  localparam int W_CNT  = 3;
  localparam int W_DST  = 4;
  localparam int W_SRC  = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EXEC, ST_WAIT, ST_RELINK
  } walk_state_t;

  // error vector index: 0 master abort, 1 target abort, 2 controller abort, 3 parity
  function automatic int err_bit_pos(input int idx);
    case (idx)
      0: return 3;
      1: return 4;
      2: return 5;
      default: return 9;
    endcase
  endfunction

  function automatic logic [3:0] resp_to_err(input logic [1:0] resp);
    case (resp)
      2'd1: return 4'b0001;
      2'd2: return 4'b0010;
      2'd3: return 4'b0100;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] desc_word_addr(input logic [ADDR_W-1:0] base,
                                                       input logic [ADDR_W-1:0] idx);
    return base + (idx << 2);
  endfunction
endpackage

// File: rtl/dchain_regs.sv
module dchain_regs
  import dchain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              evt_eot,
  input  logic              evt_eoc,
  input  logic [3:0]        evt_err,
  input  logic              append_taken,
  output logic              enable,
  output logic              append_req,
  output logic              start_req,
  output logic [ADDR_W-1:0] next_addr,
  output logic              irq_eot,
  output logic              irq_eoc,
  output logic              irq_err
);
  logic wr_ctrl, wr_stat, wr_next;
  logic enable_q, append_q, eot_q, eoc_q;
  logic [3:0] err_q;
  logic [ADDR_W-1:0] next_q;
  logic [DATA_W-1:0] stat_word;

  assign wr_ctrl = reg_sel && reg_wr && (reg_addr == OFS_CTRL);
  assign wr_stat = reg_sel && reg_wr && (reg_addr == OFS_STAT);
  assign wr_next = reg_sel && reg_wr && (reg_addr == OFS_NEXT);

  assign start_req = wr_ctrl && reg_wdata[0] && !enable_q && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      append_q <= 1'b0;
      next_q   <= '0;
      eot_q    <= 1'b0;
      eoc_q    <= 1'b0;
    end else begin
      if (wr_ctrl) enable_q <= reg_wdata[0];
      append_q <= (append_q && !append_taken) || (wr_ctrl && reg_wdata[1]);
      if (wr_next) next_q <= reg_wdata;
      eot_q <= evt_eot || (eot_q && !(wr_stat && reg_wdata[BIT_EOT]));
      eoc_q <= evt_eoc || (eoc_q && !(wr_stat && reg_wdata[BIT_EOC]));
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_err
    localparam int POS = err_bit_pos(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q[g] <= 1'b0;
      else        err_q[g] <= evt_err[g] || (err_q[g] && !(wr_stat && reg_wdata[POS]));
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[BIT_BUSY] = busy;
    stat_word[BIT_EOT]  = eot_q;
    stat_word[BIT_EOC]  = eoc_q;
    for (int i = 0; i < 4; i++) stat_word[err_bit_pos(i)] = err_q[i];
  end

  always_comb begin
    case (reg_addr)
      OFS_CTRL: reg_rdata = {{(DATA_W-2){1'b0}}, append_q, enable_q};
      OFS_STAT: reg_rdata = stat_word;
      OFS_CUR:  reg_rdata = cur_addr;
      OFS_NEXT: reg_rdata = next_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign enable     = enable_q;
  assign append_req = append_q;
  assign next_addr  = next_q;
  assign irq_eot    = eot_q;
  assign irq_eoc    = eoc_q;
  assign irq_err    = |err_q;

  AST_W1C_EOT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[BIT_EOT] && !evt_eot) |=> !irq_eot); // R6
  AST_W1C_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !reg_wdata[BIT_EOC] && irq_eoc) |=> irq_eoc); // R6
  AST_APPEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (append_taken && !(wr_ctrl && reg_wdata[1])) |=> !append_req); // R7
endmodule

// File: rtl/dchain_walker.sv
module dchain_walker
  import dchain_pkg::*;
#(
  parameter int DESC_WORDS = 7,
  parameter int CNT_W      = 24
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start_req,
  input  logic              append_req,
  input  logic [ADDR_W-1:0] next_addr,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              evt_eot,
  output logic              evt_eoc,
  output logic [3:0]        evt_err,
  output logic              append_taken,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [1:0]        mem_resp,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              op_start,
  output logic [DATA_W-1:0] op_ctrl,
  output logic [DATA_W-1:0] op_aux,
  output logic [CNT_W-1:0]  op_count,
  output logic [ADDR_W-1:0] op_dst,
  output logic [ADDR_W-1:0] op_src,
  input  logic              op_done,
  input  logic              op_perr
);
  localparam int WIDX_W = $clog2(DESC_WORDS);
  localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(DESC_WORDS - 1);

  walk_state_t st_q;
  logic [WIDX_W-1:0] widx_q;
  logic [ADDR_W-1:0] cur_q, link_q, dst_q, src_q;
  logic [DATA_W-1:0] ctrl_q, aux_q;
  logic [CNT_W-1:0]  cnt_q;
  logic at_end_q;

  logic rd_ack, resp_bad, done_evt, relink_go, start_zero;

  assign rd_ack     = (st_q == ST_FETCH || st_q == ST_RELINK) && mem_ack;
  assign resp_bad   = mem_resp != 2'd0;
  assign done_evt   = (st_q == ST_WAIT) && op_done;
  assign start_zero = (st_q == ST_IDLE) && start_req && (next_addr == '0);
  assign relink_go  = (st_q == ST_IDLE) && !start_req && at_end_q && enable && append_req;

  always_comb begin
    evt_err      = '0;
    evt_eot      = 1'b0;
    evt_eoc      = start_zero;
    append_taken = (st_q == ST_RELINK) && mem_ack;
    if (rd_ack) evt_err = resp_to_err(mem_resp);
    if (done_evt) begin
      if (op_perr) evt_err[3] = 1'b1;
      else begin
        evt_eot = ctrl_q[0];
        evt_eoc = (link_q == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      widx_q   <= '0;
      cur_q    <= '0;
      link_q   <= '0;
      ctrl_q   <= '0;
      aux_q    <= '0;
      cnt_q    <= '0;
      dst_q    <= '0;
      src_q    <= '0;
      at_end_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_req) begin
            at_end_q <= 1'b0;
            if (next_addr != '0) begin
              cur_q  <= next_addr;
              widx_q <= '0;
              st_q   <= ST_FETCH;
            end
          end else if (relink_go) begin
            st_q <= ST_RELINK;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            if (resp_bad) begin
              st_q <= ST_IDLE;
            end else begin
              if (widx_q == WIDX_W'(W_LINK)) link_q <= mem_rdata;
              if (widx_q == WIDX_W'(W_CTRL)) ctrl_q <= mem_rdata;
              if (widx_q == WIDX_W'(W_AUX))  aux_q  <= mem_rdata;
              if (widx_q == WIDX_W'(W_CNT))  cnt_q  <= mem_rdata[CNT_W-1:0];
              if (widx_q == WIDX_W'(W_DST))  dst_q  <= mem_rdata;
              if (widx_q == WIDX_W'(W_SRC))  src_q  <= mem_rdata;
              if (widx_q == LAST_IDX) st_q <= ST_EXEC;
              else                    widx_q <= widx_q + 1'b1;
            end
          end
        end
        ST_EXEC: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (op_done) begin
            if (op_perr) begin
              st_q <= ST_IDLE;
            end else if (link_q == '0) begin
              at_end_q <= 1'b1;
              st_q     <= ST_IDLE;
            end else if (!enable) begin
              st_q <= ST_IDLE;
            end else begin
              cur_q  <= link_q;
              widx_q <= '0;
              st_q   <= ST_FETCH;
            end
          end
        end
        ST_RELINK: begin
          if (mem_ack) begin
            if (resp_bad) begin
              at_end_q <= 1'b0;
              st_q     <= ST_IDLE;
            end else if (mem_rdata == '0) begin
              st_q <= ST_IDLE;
            end else begin
              at_end_q <= 1'b0;
              cur_q    <= mem_rdata;
              widx_q   <= '0;
              st_q     <= ST_FETCH;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = st_q != ST_IDLE;
  assign cur_addr = cur_q;
  assign mem_req  = (st_q == ST_FETCH) || (st_q == ST_RELINK);
  assign mem_addr = (st_q == ST_RELINK) ? cur_q
                                         : desc_word_addr(cur_q, ADDR_W'(widx_q));
  assign op_start = st_q == ST_EXEC;
  assign op_ctrl  = ctrl_q;
  assign op_aux   = aux_q;
  assign op_count = cnt_q;
  assign op_dst   = dst_q;
  assign op_src   = src_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R3
  AST_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_err) |=> (!busy && !op_start)); // R9
  AST_EOC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_eoc |=> !busy); // R4
  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_zero |=> !mem_req); // R12
endmodule

// File: rtl/dchain_ctrl.sv
module dchain_ctrl
  import dchain_pkg::*;
#(
  parameter int DESC_WORDS = 7,
  parameter int CNT_W      = 24
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_ack,
  input  logic [1:0]        mem_resp,
  input  logic [31:0]       mem_rdata,
  output logic              op_start,
  output logic [31:0]       op_ctrl,
  output logic [31:0]       op_aux,
  output logic [CNT_W-1:0]  op_count,
  output logic [31:0]       op_dst,
  output logic [31:0]       op_src,
  input  logic              op_done,
  input  logic              op_perr,
  output logic              irq_eot,
  output logic              irq_eoc,
  output logic              irq_err
);
  logic busy, enable, append_req, start_req, append_taken;
  logic evt_eot, evt_eoc;
  logic [3:0] evt_err;
  logic [ADDR_W-1:0] cur_addr, next_addr;

  dchain_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .cur_addr(cur_addr),
    .evt_eot(evt_eot), .evt_eoc(evt_eoc), .evt_err(evt_err),
    .append_taken(append_taken),
    .enable(enable), .append_req(append_req), .start_req(start_req),
    .next_addr(next_addr),
    .irq_eot(irq_eot), .irq_eoc(irq_eoc), .irq_err(irq_err)
  );

  dchain_walker #(.DESC_WORDS(DESC_WORDS), .CNT_W(CNT_W)) u_walker (
    .clk(clk), .rst_n(rst_n),
    .enable(enable), .start_req(start_req), .append_req(append_req),
    .next_addr(next_addr),
    .busy(busy), .cur_addr(cur_addr),
    .evt_eot(evt_eot), .evt_eoc(evt_eoc), .evt_err(evt_err),
    .append_taken(append_taken),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_resp(mem_resp), .mem_rdata(mem_rdata),
    .op_start(op_start), .op_ctrl(op_ctrl), .op_aux(op_aux),
    .op_count(op_count), .op_dst(op_dst), .op_src(op_src),
    .op_done(op_done), .op_perr(op_perr)
  );

  AST_IRQ_EOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_eot |=> irq_eot); // R11
  AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> busy); // R2
endmodule

// File: tb/dchain_ctrl_bench.sv
`timescale 1ns/1ps
module dchain_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [1:0] mem_resp = '0;
  logic op_start, op_done = 1'b0, op_perr = 1'b0;
  logic [31:0] op_ctrl, op_aux, op_dst, op_src;
  logic [23:0] op_count;
  logic irq_eot, irq_eoc, irq_err;

  int n_chk = 0, n_err = 0, n_ops = 0;
  logic [31:0] mem [0:255];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [1:0]  err_code = 2'd0;
  logic        perr_inject = 1'b0;
  logic [31:0] l_ctrl, l_aux, l_dst, l_src;
  logic [23:0] l_cnt;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  dchain_ctrl u_dchain_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_resp(mem_resp), .mem_rdata(mem_rdata),
    .op_start(op_start), .op_ctrl(op_ctrl), .op_aux(op_aux),
    .op_count(op_count), .op_dst(op_dst), .op_src(op_src),
    .op_done(op_done), .op_perr(op_perr),
    .irq_eot(irq_eot), .irq_eoc(irq_eoc), .irq_err(irq_err)
  );

  // memory responder
  initial forever begin
    @(negedge clk);
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_resp = 2'd0;
    end else if (mem_req) begin
      mem_ack = 1'b1;
      mem_rdata = mem[mem_addr[9:2]];
      mem_resp = (mem_addr == err_addr) ? err_code : 2'd0;
    end
  end

  // datapath model
  initial forever begin
    @(posedge clk); #1;
    if (op_start) begin
      n_ops++;
      l_ctrl = op_ctrl; l_aux = op_aux; l_cnt = op_count;
      l_dst = op_dst; l_src = op_src;
      repeat (3) @(negedge clk);
      op_done = 1'b1; op_perr = perr_inject;
      @(negedge clk);
      op_done = 1'b0; op_perr = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 2000; i++) begin
      reg_read(8'h04, s);
      if (!s[13]) break;
    end
  endtask

  task automatic put_desc(input int base, input logic [31:0] link, input logic [31:0] ctl,
                          input logic [31:0] aux, input logic [31:0] cnt,
                          input logic [31:0] dst, input logic [31:0] src);
    mem[base/4 + 0] = link; mem[base/4 + 1] = ctl; mem[base/4 + 2] = aux;
    mem[base/4 + 3] = cnt;  mem[base/4 + 4] = dst; mem[base/4 + 5] = 32'h0;
    mem[base/4 + 6] = src;
  endtask

  task automatic start_at(input logic [31:0] a);
    reg_write(8'h00, 32'h0);
    reg_write(8'h24, a);
    reg_write(8'h00, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_read(8'h00, v); chk("R1 ctrl", v, 32'h0);
    reg_read(8'h04, v); chk("R1 status", v, 32'h0);
    reg_read(8'h08, v); chk("R1 cur", v, 32'h0);
    chk("R1 irq/req", {28'h0, irq_eot, irq_eoc, irq_err, mem_req}, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    int b = n_ops;
    put_desc(32'h40, 32'h0, 32'h1, 32'hA5A5_0001, 32'hFF12_3456, 32'h1000, 32'h2000);
    start_at(32'h40);
    reg_read(8'h04, v); chk("R2 busy bit13", {31'h0, v[13]}, 32'h1);
    wait_idle();
    chk("R3 one op", n_ops - b, 1);
    chk("R3 count 24b", {8'h0, l_cnt}, 32'h0012_3456);
    chk("R3 ctrl", l_ctrl, 32'h1);
    chk("R3 aux", l_aux, 32'hA5A5_0001);
    chk("R3 dst", l_dst, 32'h1000);
    chk("R3 src", l_src, 32'h2000);
    reg_read(8'h04, v); chk("R4 R5 status eot+eoc", v, 32'h1800);
    reg_read(8'h08, v); chk("R2 cur", v, 32'h40);
    chk("R11 irq", {29'h0, irq_eot, irq_eoc, irq_err}, 32'h6);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    reg_write(8'h04, 32'h0);
    reg_read(8'h04, v); chk("R6 write 0 keeps", v, 32'h1800);
    reg_write(8'h04, 32'h1000);
    reg_read(8'h04, v); chk("R6 clear eot", v, 32'h0800);
    chk("R11 irq_eot low", {31'h0, irq_eot}, 32'h0);
    reg_write(8'h04, 32'h0800);
    reg_read(8'h04, v); chk("R6 clear eoc", v, 32'h0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int b = n_ops;
    put_desc(32'h80,  32'hC0,  32'h0, 32'h11, 32'h10, 32'h3000, 32'h4000);
    put_desc(32'hC0,  32'h100, 32'h0, 32'h22, 32'h20, 32'h3100, 32'h4100);
    put_desc(32'h100, 32'h0,   32'h0, 32'h33, 32'hFFFF_FFFF, 32'h3200, 32'h4200);
    start_at(32'h80);
    wait_idle();
    chk("R4 three ops", n_ops - b, 3);
    chk("R4 last src", l_src, 32'h4200);
    chk("R3 count max", {8'h0, l_cnt}, 32'h00FF_FFFF);
    reg_read(8'h08, v); chk("R4 cur last", v, 32'h100);
    reg_read(8'h04, v); chk("R5 no eot, eoc", v, 32'h0800);
  endtask

  task automatic t_append();
    logic [31:0] v;
    int b = n_ops;
    reg_write(8'h04, 32'h0800);
    put_desc(32'h140, 32'h0, 32'h1, 32'h44, 32'h8, 32'h3300, 32'h4300);
    mem[32'h100/4] = 32'h140;
    reg_write(8'h00, 32'h3);
    wait_idle();
    chk("R7 appended op", n_ops - b, 1);
    chk("R7 appended src", l_src, 32'h4300);
    reg_read(8'h08, v); chk("R7 cur", v, 32'h140);
    reg_read(8'h00, v); chk("R7 resume cleared", v, 32'h1);
    reg_read(8'h04, v); chk("R7 status", v, 32'h1800);
    reg_write(8'h04, 32'h1800);
    b = n_ops;
    reg_write(8'h00, 32'h3);
    repeat (10) @(negedge clk);
    reg_read(8'h00, v); chk("R7 zero link clears resume", v, 32'h1);
    reg_read(8'h08, v); chk("R7 zero link cur kept", v, 32'h140);
    chk("R7 zero link no op", n_ops - b, 0);
    reg_read(8'h04, v); chk("R7 zero link status", v, 32'h0);
  endtask

  task automatic t_zero_start();
    logic [31:0] v;
    int b = n_ops;
    start_at(32'h0);
    repeat (4) @(negedge clk);
    reg_read(8'h04, v); chk("R12 eoc at once", v, 32'h0800);
    chk("R12 no op", n_ops - b, 0);
    reg_read(8'h08, v); chk("R12 cur kept", v, 32'h140);
    reg_write(8'h04, 32'h0800);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    int b = n_ops;
    put_desc(32'h180, 32'h1C0, 32'h0, 32'h55, 32'h4, 32'h3400, 32'h4400);
    put_desc(32'h1C0, 32'h0,   32'h0, 32'h66, 32'h4, 32'h3500, 32'h4500);
    start_at(32'h180);
    for (int i = 0; i < 500 && n_ops == b; i++) @(negedge clk);
    reg_write(8'h00, 32'h0);
    wait_idle();
    chk("R8 one op only", n_ops - b, 1);
    reg_read(8'h08, v); chk("R8 cur first", v, 32'h180);
    reg_read(8'h04, v); chk("R8 idle no flags", v, 32'h0);
  endtask

  task automatic t_mem_err();
    logic [31:0] v;
    int b;
    for (int c = 1; c < 4; c++) begin
      b = n_ops;
      put_desc(32'h200, 32'h0, 32'h1, 32'h0, 32'h4, 32'h0, 32'h0);
      err_addr = 32'h208; err_code = 2'(c);
      start_at(32'h200);
      wait_idle();
      reg_read(8'h04, v);
      chk("R9 error bit", v, (c == 1) ? 32'h8 : (c == 2) ? 32'h10 : 32'h20);
      chk("R9 no op", n_ops - b, 0);
      chk("R11 irq_err", {31'h0, irq_err}, 32'h1);
      reg_write(8'h04, v);
      reg_read(8'h04, v); chk("R6 error cleared", v, 32'h0);
    end
    err_addr = 32'hFFFF_FFFF; err_code = 2'd0;
  endtask

  task automatic t_parity();
    logic [31:0] v;
    int b = n_ops;
    put_desc(32'h240, 32'h40, 32'h1, 32'h0, 32'h4, 32'h0, 32'h0);
    perr_inject = 1'b1;
    start_at(32'h240);
    wait_idle();
    perr_inject = 1'b0;
    reg_read(8'h04, v); chk("R10 parity only", v, 32'h200);
    chk("R10 halted", n_ops - b, 1);
    reg_read(8'h08, v); chk("R10 cur", v, 32'h240);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_w1c();
    t_chain();
    t_append();
    t_zero_start();
    t_disable();
    t_mem_err();
    t_parity();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule